// File: doc/BRIEF.md
# Duplex Function Checker with Encoded Shadow Copy

This block evaluates one fixed three-input, two-output logic function twice and raises an error flag whenever the two copies cannot be trusted to agree. The primary copy holds the raw input bits in its own register and evaluates the function directly. The shadow copy does not hold a replica of the inputs. It holds a 3-bit code word chosen by an encoding network. Inputs that give the same function result share one code word, and every pair of distinct code words differs in at least two bit positions. A decoder turns the code word back into the function result. It also produces a validity flag, which is set for every word that is not a code word.

Because of that spacing, one stuck bit in the shadow register yields either the correct code word or a non-code word. It can never yield another valid code word. A comparator raises the error output when the two results differ or when the flag is set. For any pair of single stuck-at faults, one in each register, the block therefore either presents the correct result or asserts the error output. Stuck-at injection ports let a test environment place one fault on each register's stored value.

Top module: `dup_enc_guard`

## Requirements
- R1: After reset both registers represent input 000: the primary register holds 000, the shadow register holds code 001, `result` is 00 and `error` is 0.
- R2: On a rising clock edge with `load` high, both registers capture `din` = {a,b,c} (a in bit 2). From that edge on, `result` = f(din), where f maps 000→00, 001→00, 010→01, 011→10, 100→11, 101→11, 110→01, 111→10.
- R3: On a rising edge with `load` low, neither register changes, so `result` and `error` stay as they were, whatever `din` is.
- R4: With no fault enabled, `error` is 0 for every loaded input.
- R5: The shadow register receives code 001 for inputs 000/001, code 010 for 010/110, code 111 for 011/111 and code 100 for 100/101. Any two of these codes differ in at least two bits.
- R6: The shadow decoder maps 001→00, 010→01, 111→10 and 100→11 with the flag clear. For the non-code words 000, 011, 101 and 110 it sets the flag, and a set flag forces `error` to 1.
- R7: `error` is 1 whenever the primary result differs from the shadow result.
- R8: With at most one stuck bit in each register, either `result` equals f of the loaded input or `error` is 1.
- R9: `result` comes from the primary copy only. A fault in the shadow register alone leaves `result` equal to f of the loaded input.
- R10: A fault enable forces stored bit `flt*_pos` (bit 0 is the LSB) of its register to `flt*_val`. The fault overlays the stored value only and is not written into the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture strobe for both registers |
| din | input | IN_W (3) | Function input {a,b,c} |
| flt1_en | input | 1 | Enables a stuck bit on the primary register |
| flt1_pos | input | POS1_W (2) | Stuck bit index in the primary register |
| flt1_val | input | 1 | Stuck value for the primary register |
| flt2_en | input | 1 | Enables a stuck bit on the shadow register |
| flt2_pos | input | POS2_W (2) | Stuck bit index in the shadow register |
| flt2_val | input | 1 | Stuck value for the shadow register |
| result | output | OUT_W (2) | Function result from the primary copy |
| error | output | 1 | Mismatch or non-code word detected |

## Verification
Two detection paths can fire in the same cycle: the shadow flag for a non-code word, and the result mismatch from a corrupted primary copy. The bench provokes both at once by placing one stuck bit in each register. For example, input 000 with primary bit 2 stuck at 1 and shadow bit 0 stuck at 0 gives primary result 11 and shadow word 000. The bench predicts `error` from its own tables of f, the code assignment and the decoder. Across every input and every pair of single faults, it judges that the result is correct or that the error output is set.

// File: rtl/dup_enc_guard_pkg.sv
package dup_enc_guard_pkg;

   // reference function: {a,b,c} -> {f1,f2}
   function automatic logic [1:0] ref_fn(input logic [2:0] abc);
      logic [1:0] r;
      unique case (abc)
         3'b000, 3'b001: r = 2'b00;
         3'b010, 3'b110: r = 2'b01;
         3'b011, 3'b111: r = 2'b10;
         default:        r = 2'b11;
      endcase
      return r;
   endfunction

   // symbol encoding for the shadow copy (pairwise distance two)
   function automatic logic [2:0] sym_code(input logic [2:0] abc);
      logic [2:0] r;
      unique case (abc)
         3'b000, 3'b001: r = 3'b001;
         3'b010, 3'b110: r = 3'b010;
         3'b011, 3'b111: r = 3'b111;
         default:        r = 3'b100;
      endcase
      return r;
   endfunction

   function automatic logic is_code(input logic [2:0] w);
      return (w == 3'b001) || (w == 3'b010) || (w == 3'b111) || (w == 3'b100);
   endfunction

endpackage

// File: rtl/dup_enc_guard_reg.sv
module dup_enc_guard_reg #(
   parameter int          W     = 3,
   parameter int          POS_W = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [W-1:0]     d,
   input  logic             flt_en,
   input  logic [POS_W-1:0] flt_pos,
   input  logic             flt_val,
   output logic [W-1:0]     q_raw,
   output logic [W-1:0]     q
);

   if ((1 << POS_W) < W) begin : g_bad_pos
      $error("POS_W too narrow for W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_raw <= RST_VAL;
      else if (load) q_raw <= d;
   end

   // stuck-at overlay, one selector per stored bit
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign q[i] = (flt_en && (flt_pos == POS_W'(i))) ? flt_val : q_raw[i];
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q_raw == $past(d)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q_raw));

   assert_overlay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_en |-> (q == q_raw));

endmodule

// File: rtl/dup_enc_guard_enc.sv
module dup_enc_guard_enc #(
   parameter int IN_W   = 3,
   parameter int CODE_W = 3
) (
   input  logic [IN_W-1:0]   din,
   output logic [CODE_W-1:0] code
);
   import dup_enc_guard_pkg::*;

   if (IN_W != 3 || CODE_W != 3) begin : g_bad_w
      $error("encoder supports IN_W=3, CODE_W=3 only");
   end

   assign code = sym_code(din);

endmodule

// File: rtl/dup_enc_guard_shadow.sv
module dup_enc_guard_shadow #(
   parameter int CODE_W = 3,
   parameter int OUT_W  = 2
) (
   input  logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0]  res,
   output logic              bad
);

   if (CODE_W != 3 || OUT_W != 2) begin : g_bad_w
      $error("shadow decoder supports CODE_W=3, OUT_W=2 only");
   end

   logic [2:0] word;   // {o1,o2,o3}

   always_comb begin
      unique case (code)
         3'b001:  word = 3'b000;
         3'b010:  word = 3'b010;
         3'b111:  word = 3'b100;
         3'b100:  word = 3'b110;
         default: word = 3'b001;
      endcase
   end

   assign res = word[2:1];
   assign bad = word[0];

endmodule

// File: rtl/dup_enc_guard.sv
module dup_enc_guard #(
   parameter int IN_W   = 3,
   parameter int OUT_W  = 2,
   parameter int CODE_W = 3,
   parameter int POS1_W = 2,
   parameter int POS2_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IN_W-1:0]   din,
   input  logic              flt1_en,
   input  logic [POS1_W-1:0] flt1_pos,
   input  logic              flt1_val,
   input  logic              flt2_en,
   input  logic [POS2_W-1:0] flt2_pos,
   input  logic              flt2_val,
   output logic [OUT_W-1:0]  result,
   output logic              error
);
   import dup_enc_guard_pkg::*;

   localparam logic [CODE_W-1:0] SHADOW_RST = CODE_W'(3'b001);

   if (IN_W != 3 || OUT_W != 2 || CODE_W != 3) begin : g_bad_w
      $error("dup_enc_guard supports the 3-in/2-out function only");
   end

   logic [IN_W-1:0]   p_raw, p_q;
   logic [CODE_W-1:0] s_d, s_raw, s_q;
   logic [OUT_W-1:0]  p_res, s_res;
   logic              s_bad;

   dup_enc_guard_reg #(.W(IN_W), .POS_W(POS1_W), .RST_VAL('0)) i_preg (
      .clk(clk), .rst_n(rst_n), .load(load), .d(din),
      .flt_en(flt1_en), .flt_pos(flt1_pos), .flt_val(flt1_val),
      .q_raw(p_raw), .q(p_q));

   dup_enc_guard_enc #(.IN_W(IN_W), .CODE_W(CODE_W)) i_enc (
      .din(din), .code(s_d));

   dup_enc_guard_reg #(.W(CODE_W), .POS_W(POS2_W), .RST_VAL(SHADOW_RST)) i_sreg (
      .clk(clk), .rst_n(rst_n), .load(load), .d(s_d),
      .flt_en(flt2_en), .flt_pos(flt2_pos), .flt_val(flt2_val),
      .q_raw(s_raw), .q(s_q));

   assign p_res = ref_fn(p_q);

   dup_enc_guard_shadow #(.CODE_W(CODE_W), .OUT_W(OUT_W)) i_shadow (
      .code(s_q), .res(s_res), .bad(s_bad));

   assign result = p_res;
   assign error  = s_bad | (p_res != s_res);

   // shadow register only ever stores code words
   assert_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_code(s_raw));

   assert_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt1_en && !flt2_en) |-> !error);

   assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_code(s_q) |-> error);

   assert_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_res != s_res) |-> error);

   assert_secure_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !error |-> (result == ref_fn(p_raw)));

   assert_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
      s_raw == sym_code(p_raw));

endmodule

// File: tb/test_dup_enc_guard.sv
`timescale 1ns/1ps
module test_dup_enc_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [2:0] din = '0;
   logic       flt1_en = 1'b0, flt1_val = 1'b0;
   logic       flt2_en = 1'b0, flt2_val = 1'b0;
   logic [1:0] flt1_pos = '0, flt2_pos = '0;
   logic [1:0] result;
   logic       error;

   int n_chk = 0, n_bad = 0;
   logic [2:0] m_in;    // last loaded input (bench model)

   always #2.5 clk = ~clk;

   dup_enc_guard i_dup_enc_guard (
      .clk(clk), .rst_n(rst_n), .load(load), .din(din),
      .flt1_en(flt1_en), .flt1_pos(flt1_pos), .flt1_val(flt1_val),
      .flt2_en(flt2_en), .flt2_pos(flt2_pos), .flt2_val(flt2_val),
      .result(result), .error(error));

   // expected-value tables from the requirements
   function automatic logic [1:0] exp_f(input logic [2:0] v);
      case (v)
         3'b000: return 2'b00; 3'b001: return 2'b00;
         3'b010: return 2'b01; 3'b011: return 2'b10;
         3'b100: return 2'b11; 3'b101: return 2'b11;
         3'b110: return 2'b01; default: return 2'b10;
      endcase
   endfunction

   function automatic logic [2:0] exp_code(input logic [2:0] v);
      case (v)
         3'b000, 3'b001: return 3'b001;
         3'b010, 3'b110: return 3'b010;
         3'b011, 3'b111: return 3'b111;
         default:        return 3'b100;
      endcase
   endfunction

   // returns {res, flag}
   function automatic logic [2:0] exp_dec(input logic [2:0] w);
      case (w)
         3'b001: return 3'b000;
         3'b010: return 3'b010;
         3'b111: return 3'b100;
         3'b100: return 3'b110;
         default: return 3'b001;
      endcase
   endfunction

   function automatic logic [2:0] stick(input logic [2:0] v, input logic en,
                                        input logic [1:0] pos, input logic val);
      logic [2:0] r = v;
      if (en && pos < 2'd3) r[pos] = val;
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (in=%b f1=%b/%0d/%b f2=%b/%0d/%b)",
                  req, act, exp, m_in, flt1_en, flt1_pos, flt1_val,
                  flt2_en, flt2_pos, flt2_val);
      end
   endtask

   // full prediction of both outputs for the model state and current faults
   task automatic chk_model(input string req);
      logic [2:0] e1, e2, dw;
      logic [1:0] pf;
      logic       ee;
      e1 = stick(m_in, flt1_en, flt1_pos, flt1_val);
      e2 = stick(exp_code(m_in), flt2_en, flt2_pos, flt2_val);
      pf = exp_f(e1);
      dw = exp_dec(e2);
      ee = dw[0] | (dw[2:1] != pf);
      chk({req, " result"}, 32'(result), 32'(pf));
      chk({req, " error"}, 32'(error), 32'(ee));
      // R8 fault-secure judgement
      chk("R8 secure", 32'((result == exp_f(m_in)) || error), 32'd1);
   endtask

   task automatic do_load(input logic [2:0] v);
      @(negedge clk);
      din = v; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      m_in = v;
      #0.5;
   endtask

   task automatic set_flt(input int c1, input int c2);
      flt1_en = (c1 != 0); flt1_pos = 2'((c1 - 1) / 2); flt1_val = 1'((c1 - 1) % 2);
      flt2_en = (c2 != 0); flt2_pos = 2'((c2 - 1) / 2); flt2_val = 1'((c2 - 1) % 2);
      if (c1 == 0) begin flt1_pos = '0; flt1_val = 1'b0; end
      if (c2 == 0) begin flt2_pos = '0; flt2_val = 1'b0; end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [1:0] r_hold;
      logic [31:0] seed;
      m_in = 3'b000;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1 reset state
      chk("R1 reset result", 32'(result), 32'd0);
      chk("R1 reset error", 32'(error), 32'd0);

      // R2/R4 every input, fault-free
      for (int v = 0; v < 8; v++) begin
         do_load(3'(v));
         chk("R2 function", 32'(result), 32'(exp_f(3'(v))));
         chk("R4 no error", 32'(error), 32'd0);
      end

      // R3 load low: din changes are ignored
      do_load(3'b100);
      r_hold = result;
      @(negedge clk); din = 3'b000; load = 1'b0;
      repeat (2) @(negedge clk);
      #0.5;
      chk("R3 hold result", 32'(result), 32'(r_hold));
      chk("R3 hold error", 32'(error), 32'd0);
      // fault only in shadow reveals shadow still holds code of 100: bit2 stuck 0 -> 000
      set_flt(0, 5); #0.5;
      chk("R3 shadow kept", 32'(error), 32'd1);
      set_flt(0, 0);

      // R6 and R9: shadow-only fault making a non-code word (000 -> code 001, bit0 stuck 0)
      do_load(3'b000);
      set_flt(0, 1); #0.5;
      chk("R6 flag error", 32'(error), 32'd1);
      chk("R9 result from primary", 32'(result), 32'd0);
      // R10 shadow fault matching stored bit has no effect (bit0 stuck 1)
      set_flt(0, 2); #0.5;
      chk("R10 benign fault", 32'(error), 32'd0);
      // R7 primary-only fault: bit2 stuck 1 -> primary 100 -> 11 vs shadow 00
      set_flt(6, 0); #0.5;
      chk("R7 mismatch", 32'(error), 32'd1);
      chk("R10 overlay result", 32'(result), 32'd3);
      // both paths in the same cycle
      set_flt(6, 1); #0.5;
      chk("R6 R7 combined", 32'(error), 32'd1);
      set_flt(0, 0); #0.5;
      chk("R10 fault removed", 32'(error), 32'd0);

      // R8 exhaustive: every input against every single-fault pair
      for (int v = 0; v < 8; v++) begin
         do_load(3'(v));
         for (int c1 = 0; c1 < 7; c1++) begin
            for (int c2 = 0; c2 < 7; c2++) begin
               @(negedge clk);
               set_flt(c1, c2);
               #0.5;
               chk_model("R8 pair");
            end
         end
         set_flt(0, 0);
      end

      // constrained random mix of loads, holds and faults
      for (int k = 0; k < 400; k++) begin
         logic ld;
         logic [2:0] nv;
         @(negedge clk);
         ld = ($urandom % 3) != 0;
         nv = 3'($urandom);
         din = nv; load = ld;
         set_flt(($urandom % 4 == 0) ? int'($urandom % 7) : 0,
                 ($urandom % 4 == 0) ? int'($urandom % 7) : 0);
         @(negedge clk);
         load = 1'b0;
         if (ld) m_in = nv;
         #0.5;
         chk_model(ld ? "R2 random" : "R3 random");
      end

      // reset again mid-run returns to R1 state
      set_flt(0, 0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; m_in = 3'b000;
      #0.5;
      chk("R1 re-reset result", 32'(result), 32'd0);
      chk("R1 re-reset error", 32'(error), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule